// File: doc/BRIEF.md
# Quarter-Bit Serial Framer with Idle Timeout

This block is the serialising core of an asynchronous serial port. A transmit half takes bytes from an upstream byte queue over a valid/ready stream and shifts them onto a line that rests high. A receive half watches the incoming line, rebuilds characters and hands each one downstream with its error flags, also over valid/ready. Both halves share one programmable divisor. The divisor sets the length of a quarter bit in clock cycles, so every bit lasts four quarter ticks and the receiver oversamples four times. Character shape is taken from a 5-bit line-control word: word length of 5 to 8 bits, one or two stop bits, and parity that is off, odd or even.

An idle timer counts whole bit times, which are four quarter ticks each, from the most recent received character. When the count reaches the programmed limit while the downstream queue still reports unread data, it emits a single timeout pulse. This pulse lets software collect a short tail of data that never reaches a fill threshold. The queues themselves and any register decode sit outside this block.

Back-pressure rules. On transmit, a byte moves on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while no character is on the line, so the upstream side holds a byte until the previous frame has completely finished. On receive, `rx_valid` stays high and `rx_data`/`rx_err` stay frozen until a clock edge with `rx_ready` high. The serial line cannot be paused, so if a new character completes while one is still held, the new character is discarded and the held character is marked with the overrun flag.

Top module: `qbit_uart`

## Requirements
- R1: A quarter tick occurs once every `divisor` clock cycles (a divisor of 0 or 1 gives one tick per cycle), and every transmitted bit lasts exactly four ticks, so with divisor 3 a data bit is 12 cycles long.
- R2: `line_ctrl[1:0]` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Transmit sends only that many low bits of `tx_data`. Receive returns them right-aligned in `rx_data`, with the unused upper bits at zero.
- R3: When `line_ctrl[2]` is 1, the transmitter sends two stop bits; when it is 0, it sends one. The receiver checks only the first stop bit.
- R4: When `line_ctrl[3]` is 1, a parity bit follows the data bits. `line_ctrl[4]` = 1 selects even parity and 0 selects odd parity, where the count covers the data bits and the parity bit together.
- R5: The transmit frame is a low start bit, then the data bits LSB first, then the parity bit if enabled, then the high stop bits. The line rests high when idle. `tx_ready` is high only when idle and drops on the cycle after a byte is accepted.
- R6: The receiver starts a character on a falling edge of `rx_line` and confirms the start bit on the second quarter tick. A low pulse that has already ended by then is ignored and produces no character.
- R7: The receiver samples each later bit on the fourth tick after the previous sample, which falls in the middle of the bit. `rx_err[1]` reports a parity mismatch when parity is enabled.
- R8: A low first stop bit sets the framing flag `rx_err[2]`. A character in which the data bits, the parity bit (if enabled) and the stop bit are all low also sets the break flag `rx_err[3]`.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_data` and `rx_err` hold their values. A character that completes at that time is dropped, and the overrun flag `rx_err[0]` of the held character is set.
- R10: The timeout counter restarts at every received character and advances once per four quarter ticks. It pulses `rx_timeout` for one cycle when the count reaches `idle_limit` while `unread_pending` is high. It fires only once until the next character arrives.
- R11: `rx_timeout` never pulses while `idle_limit` is zero or while `unread_pending` is low.
- R12: After reset, `tx_line` is high, `tx_ready` is high, `rx_valid` is low and `rx_timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | DIV_W | Quarter-bit period in clock cycles |
| idle_limit | input | TMO_W | Idle timeout in bit times; 0 disables the timeout |
| line_ctrl | input | 5 | Word length [1:0], two stop bits [2], parity enable [3], even parity [4] |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and accepting |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character, right-aligned |
| rx_err | output | 4 | Break [3], framing [2], parity [1], overrun [0] |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Downstream takes the held character |
| unread_pending | input | 1 | Downstream queue still holds unread data |
| rx_timeout | output | 1 | One-cycle idle timeout pulse |

## Verification
The bench sends eight frame shapes through the transmitter and decodes the line independently. These shapes cover every word length, both stop-bit counts, and parity off, odd and even. Their data patterns would expose a reversed bit order, masking of the upper bits, or the wrong parity sense. The same frames are then driven into the receiver. Hand-built faulty frames follow: one with flipped parity, one with a low stop bit, and an all-zero line. These show that each error flag responds only to its own fault, and that break also implies a framing error. A short glitch, two frames with no reader in between, and timeout runs with the limit set to zero, with nothing pending, and with a live limit separate the remaining start-validation, overrun and single-fire behaviours.

// File: rtl/qbit_pkg.sv
`timescale 1ns/1ps
package qbit_pkg;
  localparam int QTR_PER_BIT = 4;
  localparam int QCW = $clog2(QTR_PER_BIT);
  localparam logic [QCW-1:0] QLAST = QCW'(QTR_PER_BIT - 1);
  localparam logic [QCW-1:0] QCONFIRM = QCW'(1);

  typedef enum logic [2:0] {
    FR_IDLE, FR_START, FR_DATA, FR_PARITY, FR_STOP
  } frame_st_t;

  typedef struct packed {
    logic       par_even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } line_cfg_t;

  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
    logic overrun;
  } rx_err_t;

  function automatic logic [2:0] last_index(input logic [1:0] wl);
    return 3'd4 + {1'b0, wl};
  endfunction

  function automatic logic [2:0] pad_shift(input logic [1:0] wl);
    return 3'd3 - {1'b0, wl};
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] wl,
                                      input logic even);
    logic [7:0] m;
    m = d & (8'hFF >> pad_shift(wl));
    return even ? (^m) : ~(^m);
  endfunction
endpackage

// File: rtl/qbit_tick.sv
`timescale 1ns/1ps
module qbit_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = ({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/qbit_tx.sv
`timescale 1ns/1ps
module qbit_tx import qbit_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_cfg_t cfg,
  input  logic [7:0] byte_in,
  input  logic      byte_valid,
  output logic      byte_ready,
  output logic      line_out
);
  frame_st_t      st;
  logic [QCW-1:0] qcnt;
  logic [2:0]     bitn;
  logic [7:0]     shreg;
  line_cfg_t      cfg_q;
  logic           par_q;
  logic           second_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FR_IDLE;
      qcnt        <= '0;
      bitn        <= '0;
      shreg       <= '0;
      cfg_q       <= '0;
      par_q       <= 1'b0;
      second_stop <= 1'b0;
    end else if (st == FR_IDLE) begin
      if (byte_valid) begin
        st    <= FR_START;
        shreg <= byte_in;
        cfg_q <= cfg;
        par_q <= parity_bit(byte_in, cfg.wlen, cfg.par_even);
        qcnt  <= '0;
      end
    end else if (tick) begin
      qcnt <= qcnt + 1'b1;
      if (qcnt == QLAST) begin
        case (st)
          FR_START: begin
            st   <= FR_DATA;
            bitn <= '0;
          end
          FR_DATA: begin
            shreg <= shreg >> 1;
            if (bitn == last_index(cfg_q.wlen)) begin
              st          <= cfg_q.par_en ? FR_PARITY : FR_STOP;
              second_stop <= 1'b0;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
          FR_PARITY: begin
            st          <= FR_STOP;
            second_stop <= 1'b0;
          end
          FR_STOP: begin
            if (cfg_q.two_stop && !second_stop) second_stop <= 1'b1;
            else st <= FR_IDLE;
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  assign byte_ready = (st == FR_IDLE);

  always_comb begin
    case (st)
      FR_START:  line_out = 1'b0;
      FR_DATA:   line_out = shreg[0];
      FR_PARITY: line_out = par_q;
      default:   line_out = 1'b1;
    endcase
  end

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> line_out);
  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> (!byte_ready && !line_out));
endmodule

// File: rtl/qbit_rx.sv
`timescale 1ns/1ps
module qbit_rx import qbit_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       line_in,
  output logic       done,
  output logic [7:0] data_o,
  output rx_err_t    err_o
);
  logic           s1, s2, s3;
  logic           fall;
  frame_st_t      st;
  logic [QCW-1:0] qcnt;
  logic [2:0]     bitn;
  logic [7:0]     shreg;
  logic [7:0]     aligned;
  logic [1:0]     wl_q;
  logic           pen_q, peven_q;
  logic           par_bit;
  logic           allzero;

  assign fall    = s3 && !s2;
  assign aligned = shreg >> pad_shift(wl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      qcnt    <= '0;
      bitn    <= '0;
      shreg   <= '0;
      wl_q    <= '0;
      pen_q   <= 1'b0;
      peven_q <= 1'b0;
      par_bit <= 1'b0;
      allzero <= 1'b1;
      done    <= 1'b0;
      data_o  <= '0;
      err_o   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        FR_IDLE: if (fall) begin
          st      <= FR_START;
          qcnt    <= '0;
          shreg   <= '0;
          allzero <= 1'b1;
          wl_q    <= wlen;
          pen_q   <= par_en;
          peven_q <= par_even;
        end
        FR_START: if (tick) begin
          if (qcnt == QCONFIRM) begin
            qcnt <= '0;
            bitn <= '0;
            st   <= s2 ? FR_IDLE : FR_DATA;
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
        FR_DATA: if (tick) begin
          qcnt <= qcnt + 1'b1;
          if (qcnt == QLAST) begin
            shreg   <= {s2, shreg[7:1]};
            allzero <= allzero & ~s2;
            if (bitn == last_index(wl_q)) st <= pen_q ? FR_PARITY : FR_STOP;
            else bitn <= bitn + 1'b1;
          end
        end
        FR_PARITY: if (tick) begin
          qcnt <= qcnt + 1'b1;
          if (qcnt == QLAST) begin
            par_bit <= s2;
            allzero <= allzero & ~s2;
            st      <= FR_STOP;
          end
        end
        FR_STOP: if (tick) begin
          qcnt <= qcnt + 1'b1;
          if (qcnt == QLAST) begin
            done          <= 1'b1;
            data_o        <= aligned;
            err_o.brk     <= allzero & ~s2;
            err_o.frame   <= ~s2;
            err_o.parity  <= pen_q && (par_bit != parity_bit(aligned, wl_q, peven_q));
            err_o.overrun <= 1'b0;
            st            <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_break_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_o.brk) |-> err_o.frame);
  p_glitch_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_START && tick && qcnt == QCONFIRM && s2) |=> (st == FR_IDLE));
endmodule

// File: rtl/qbit_idle_timer.sv
`timescale 1ns/1ps
module qbit_idle_timer import qbit_pkg::*; #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             char_done,
  input  logic             pending,
  input  logic [TMO_W-1:0] limit,
  output logic             fire_o
);
  logic [QCW-1:0]   qph;
  logic [TMO_W-1:0] cnt;
  logic             fired;
  logic             fire_now;

  assign fire_now = !char_done && !fired && (limit != '0) && pending && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qph    <= '0;
      cnt    <= '0;
      fired  <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      if (tick) qph <= qph + 1'b1;
      fire_o <= fire_now;
      if (char_done) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else begin
        if (tick && qph == QLAST && cnt < limit) cnt <= cnt + 1'b1;
        if (fire_now) fired <= 1'b1;
      end
    end
  end

  p_fire_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !fire_o);
  p_no_fire_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 || !pending) |=> !fire_o);
endmodule

// File: rtl/qbit_uart.sv
`timescale 1ns/1ps
module qbit_uart import qbit_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [TMO_W-1:0] idle_limit,
  input  logic [4:0]       line_ctrl,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_line,
  input  logic             rx_line,
  output logic [7:0]       rx_data,
  output logic [3:0]       rx_err,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic             unread_pending,
  output logic             rx_timeout
);
  line_cfg_t  cfg;
  logic       tick;
  logic       ch_done;
  logic [7:0] ch_data;
  rx_err_t    ch_err;
  rx_err_t    held_err;

  assign cfg = line_cfg_t'(line_ctrl);

  qbit_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  qbit_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .byte_in(tx_data), .byte_valid(tx_valid), .byte_ready(tx_ready),
    .line_out(tx_line)
  );

  qbit_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wlen(cfg.wlen),
    .par_en(cfg.par_en), .par_even(cfg.par_even), .line_in(rx_line),
    .done(ch_done), .data_o(ch_data), .err_o(ch_err)
  );

  qbit_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .char_done(ch_done),
    .pending(unread_pending), .limit(idle_limit), .fire_o(rx_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      held_err <= '0;
    end else if (ch_done) begin
      if (rx_valid && !rx_ready) begin
        held_err.overrun <= 1'b1;
      end else begin
        rx_valid <= 1'b1;
        rx_data  <= ch_data;
        held_err <= ch_err;
      end
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assign rx_err = held_err;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && ch_done) |=> rx_err[0]);
endmodule

// File: tb/qbit_uart_test.sv
`timescale 1ns/1ps
module qbit_uart_test;
  localparam int DIV = 3;
  localparam int BIT = 4 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'(DIV);
  logic [15:0] idle_limit = '0;
  logic [4:0]  line_ctrl = 5'b00011;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_line;
  logic        rx_line = 1'b1;
  logic [7:0]  rx_data;
  logic [3:0]  rx_err;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        unread_pending = 1'b0;
  logic        rx_timeout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qbit_uart uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .idle_limit(idle_limit),
    .line_ctrl(line_ctrl), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line),
    .rx_data(rx_data), .rx_err(rx_err), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .unread_pending(unread_pending), .rx_timeout(rx_timeout)
  );

  // {line_ctrl, data}
  localparam logic [12:0] VEC [0:7] = '{
    {5'b00011, 8'hA5}, {5'b00000, 8'hF3}, {5'b00101, 8'h2D}, {5'b11010, 8'h5A},
    {5'b01011, 8'h81}, {5'b11111, 8'h00}, {5'b01100, 8'h15}, {5'b11010, 8'h7F}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [4:0] l);
    return 8'((9'd1 << (5 + l[1:0])) - 1);
  endfunction

  function automatic void build(input logic [4:0] l, input logic [7:0] d,
                                output logic [15:0] f, output int n);
    int nb, ones;
    nb = 5 + int'(l[1:0]);
    f = '1; n = 0; ones = 0;
    f[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin
      f[n] = d[i]; ones += int'(d[i]); n++;
    end
    if (l[3]) begin
      f[n] = l[4] ? ones[0] : ~ones[0]; n++;
    end
    f[n] = 1'b1; n++;
    if (l[2]) begin
      f[n] = 1'b1; n++;
    end
  endfunction

  task automatic drive(input logic [15:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rx_line = f[i];
      repeat (BIT) @(negedge clk);
    end
    rx_line = 1'b1;
  endtask

  task automatic take(output logic v, output logic [7:0] d, output logic [3:0] e);
    v = rx_valid; d = rx_data; e = rx_err;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic send_decode(input logic [4:0] l, input logic [7:0] d);
    logic [15:0] exp_f, got;
    int n;
    logic busy_seen;
    build(l, d, exp_f, n);
    got = '1;
    busy_seen = 1'b1;
    line_ctrl = l;
    fork
      begin
        tx_data = d; tx_valid = 1'b1;
        @(posedge clk);
        while (!tx_ready) @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
      end
      begin
        @(negedge tx_line);
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          got[i] = tx_line;
          if (tx_ready) busy_seen = 1'b0;
          repeat (BIT) @(negedge clk);
        end
      end
    join
    chk(got[11:0] == exp_f[11:0], "R2 R3 R4 R5 tx frame", int'(got[11:0]), int'(exp_f[11:0]));
    chk(busy_seen, "R5 tx_ready low during frame", 0, 1);
    repeat (BIT) @(negedge clk);
    chk(tx_ready && tx_line, "R5 idle after frame", int'({tx_ready, tx_line}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] f;
    int n, t0, t1, wait_n;
    logic v;
    logic [7:0] d;
    logic [3:0] e;
    bit seen;

    repeat (5) @(negedge clk);
    // R12 reset state
    chk(tx_line == 1'b1, "R12 tx_line in reset", tx_line, 1);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0 && rx_timeout == 1'b0,
        "R12 ready/valid/timeout in reset", int'({tx_ready, rx_valid, rx_timeout}), 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: transmit decode, then receive the same frame
    for (int k = 0; k < 8; k++) begin
      send_decode(VEC[k][12:8], VEC[k][7:0]);
      build(VEC[k][12:8], VEC[k][7:0], f, n);
      drive(f, n);
      repeat (2 * BIT) @(negedge clk);
      take(v, d, e);
      chk(v == 1'b1, "R7 rx char delivered", v, 1);
      chk(d == (VEC[k][7:0] & mask_of(VEC[k][12:8])), "R2 R7 rx data",
          d, VEC[k][7:0] & mask_of(VEC[k][12:8]));
      chk(e == 4'b0000, "R4 R7 rx clean flags", e, 0);
    end

    // R1 bit period: 0x55 8N1, start->d0 rise to d0->d1 fall
    line_ctrl = 5'b00011;
    tx_data = 8'h55; tx_valid = 1'b1;
    @(posedge tx_line); t0 = cyc;
    tx_valid = 1'b0;
    @(negedge tx_line); t1 = cyc;
    chk(t1 - t0 == BIT, "R1 bit length in cycles", t1 - t0, BIT);
    wait (tx_ready);
    repeat (BIT) @(negedge clk);

    // R7 parity error: 8E1, 0x3C, parity bit flipped
    line_ctrl = 5'b11011;
    build(line_ctrl, 8'h3C, f, n);
    f[9] = ~f[9];
    drive(f, n);
    repeat (2 * BIT) @(negedge clk);
    take(v, d, e);
    chk(v && d == 8'h3C && e == 4'b0010, "R7 parity error flag", int'({v, d, e}), 13'h13C2);

    // R8 framing: 8N1 0x55 with low stop bit
    line_ctrl = 5'b00011;
    build(line_ctrl, 8'h55, f, n);
    f[9] = 1'b0;
    drive(f, n);
    repeat (2 * BIT) @(negedge clk);
    take(v, d, e);
    chk(v && d == 8'h55 && e == 4'b0100, "R8 framing flag only", int'({v, d, e}), 13'h1554);

    // R8 break: whole character low
    drive(16'h0000, 10);
    repeat (2 * BIT) @(negedge clk);
    take(v, d, e);
    chk(v && d == 8'h00 && e == 4'b1100, "R8 break and framing", int'({v, d, e}), 13'h100C);

    // R9 overrun: two characters, no reader
    build(line_ctrl, 8'h11, f, n);
    drive(f, n);
    repeat (BIT) @(negedge clk);
    build(line_ctrl, 8'h22, f, n);
    drive(f, n);
    repeat (2 * BIT) @(negedge clk);
    take(v, d, e);
    chk(v && d == 8'h11 && e == 4'b0001, "R9 held char with overrun", int'({v, d, e}), 13'h1111);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 second char dropped", rx_valid, 0);

    // R6 glitch ignored, then a real char still decodes
    rx_line = 1'b0;
    repeat (2) @(negedge clk);
    rx_line = 1'b1;
    repeat (8 * BIT) @(negedge clk);
    chk(rx_valid == 1'b0, "R6 short low pulse ignored", rx_valid, 0);
    build(line_ctrl, 8'hC3, f, n);
    drive(f, n);
    repeat (2 * BIT) @(negedge clk);
    take(v, d, e);
    chk(v && d == 8'hC3, "R6 receiver recovers after glitch", int'({v, d}), 9'h1C3);

    // R10 timeout after limit bit times, exactly once
    idle_limit = 16'd3;
    build(line_ctrl, 8'h5E, f, n);
    drive(f, n);
    unread_pending = 1'b1;
    wait_n = 0; seen = 1'b0;
    for (int c = 0; c < 200 && !seen; c++) begin
      @(negedge clk);
      wait_n++;
      if (rx_timeout) seen = 1'b1;
    end
    chk(seen && wait_n >= 15 && wait_n <= 45, "R10 timeout delay", wait_n, 30);
    seen = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (rx_timeout) seen = 1'b1;
    end
    chk(!seen, "R10 single pulse", seen, 0);
    take(v, d, e);

    // R11 limit zero never fires
    idle_limit = 16'd0;
    drive(f, n);
    seen = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (rx_timeout) seen = 1'b1;
    end
    chk(!seen, "R11 zero limit silent", seen, 0);
    take(v, d, e);

    // R11 nothing pending never fires
    unread_pending = 1'b0;
    idle_limit = 16'd2;
    drive(f, n);
    seen = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (rx_timeout) seen = 1'b1;
    end
    chk(!seen, "R11 no pending data silent", seen, 0);
    take(v, d, e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule